// File: doc/BRIEF.md
# Dual-Slope Conversion Phase Sequencer

This block is the digital controller of a three-and-a-half digit dual-slope analog-to-digital converter. It runs a conversion cycle that never stops and has four phases: auto-zero, signal integrate, reference de-integrate and zero integrate. Each phase drives its own switch-control output. The integrator, comparator, reference switches and oscillator sit outside the block. Its only view of the analog side is a single comparator bit (`cmp_i`, 1 when the integrator output is above zero). The clock is the oscillator clock. One count is `PRESCALE` clocks, so a small prescale value shortens simulation without changing the sequencing.

At the end of signal integrate the block latches the comparator to fix the input polarity. That polarity selects which reference switch closes during de-integrate. During de-integrate the block counts in BCD until the comparator reports that the integrator has crossed zero, then loads the signed reading into the result register and strobes a valid pulse. If the count runs to its limit, the block flags overrange and forces the following zero-integrate phase to a long fixed length, so the next reading is already correct. Auto-zero takes whatever time remains, so every cycle lasts exactly `CYCLE_COUNTS` counts.

Top module: `dualslope_seq`

## Requirements
- R1: A synchronous reset puts the block in auto-zero (only `az_o` high), clears the result, sign, overrange and valid outputs, and the first auto-zero then lasts `CYCLE_COUNTS*PRESCALE` clocks.
- R2: Exactly one of `az_o`, `int_o`, `de_up_o`, `de_dn_o`, `zi_o` is high in every cycle, and the phases follow the order auto-zero, integrate, de-integrate, zero integrate, auto-zero.
- R3: `short_o` is high in auto-zero, de-integrate and zero integrate, and low during signal integrate.
- R4: Signal integrate lasts exactly `INT_COUNTS*PRESCALE` clocks.
- R5: The comparator value on the last integrate clock sets the polarity. A 1 (positive input) selects `de_dn_o` during de-integrate and a result sign `res_neg_o`=0. A 0 selects `de_up_o` and sign 1.
- R6: De-integrate checks the comparator once per count, on the last clock of each count. If the comparator differs from the latched polarity there, the phase ends and the reading equals the number of counts completed before that count, from 0 to 1999. The reading is given as `res_k_o` (thousands, 0 or 1) and the BCD digits `res_h_o`, `res_t_o` and `res_u_o`, each 0 to 9.
- R7: The result outputs change only on the clock where `valid_o` is high. `valid_o` is a single-clock pulse at the end of each de-integrate.
- R8: If the comparator has not crossed by the check of the 2000th count, de-integrate ends with `ovr_o`=1, all reading digits 0, and a valid pulse.
- R9: After a normal reading, zero integrate ends on the first clock on which at least `ZI_MIN` clocks have elapsed and the comparator equals the latched polarity. It ends at the latest after `ZI_MAX` clocks.
- R10: After an overrange, zero integrate lasts exactly `ZI_OVR` clocks whatever the comparator does, and the following conversion returns to the R9 rule.
- R11: Successive integrate-phase starts are exactly `CYCLE_COUNTS*PRESCALE` clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| cmp_i | input | 1 | Comparator: 1 when integrator output is above zero |
| az_o | output | 1 | Auto-zero switch control |
| int_o | output | 1 | Signal integrate switch control |
| de_up_o | output | 1 | De-integrate with reference driving integrator upward (negative input) |
| de_dn_o | output | 1 | De-integrate with reference driving integrator downward (positive input) |
| zi_o | output | 1 | Zero integrate switch control |
| short_o | output | 1 | Internal input short to analog common |
| res_neg_o | output | 1 | Result sign, 1 = negative |
| res_k_o | output | 1 | Result thousands digit |
| res_h_o | output | 4 | Result hundreds digit, BCD |
| res_t_o | output | 4 | Result tens digit, BCD |
| res_u_o | output | 4 | Result units digit, BCD |
| ovr_o | output | 1 | Overrange flag of the last result |
| valid_o | output | 1 | One-clock strobe when the result updates |

## Verification
The hardest state to reach from the ports is the zero-integrate phase after an overrange. It takes a comparator that stays on the same side for 2000 full counts, and then a check that the next conversion drops back to the comparator-ended rule. The bench has a behavioural comparator that follows its own phase timeline. For each conversion it flips the comparator after a chosen number of counts and restores it after a chosen number of zero-integrate clocks. The scenario list includes a comparator that never flips, one that flips exactly at the 2000-count boundary, a normal reading right after the overrange, and readings at 0, 1 and 1999. A reset in the middle of de-integrate checks that the sequence restarts cleanly.

// File: rtl/dualslope_seq.sv
module dualslope_seq #(
  parameter int PRESCALE     = 4,
  parameter int INT_COUNTS   = 1000,
  parameter int CYCLE_COUNTS = 4000,
  parameter int ZI_MIN       = 11,
  parameter int ZI_MAX       = 140,
  parameter int ZI_OVR       = 740
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmp_i,
  output logic       az_o,
  output logic       int_o,
  output logic       de_up_o,
  output logic       de_dn_o,
  output logic       zi_o,
  output logic       short_o,
  output logic       res_neg_o,
  output logic       res_k_o,
  output logic [3:0] res_h_o,
  output logic [3:0] res_t_o,
  output logic [3:0] res_u_o,
  output logic       ovr_o,
  output logic       valid_o
);
  localparam int INT_CLK = INT_COUNTS * PRESCALE;
  localparam int CYC_CLK = CYCLE_COUNTS * PRESCALE;
  localparam int ZMAX    = (ZI_OVR > ZI_MAX) ? ZI_OVR : ZI_MAX;
  localparam int TMAX    = (INT_CLK > ZMAX) ? INT_CLK : ZMAX;
  localparam int TW      = $clog2(TMAX + 1);
  localparam int CW      = $clog2(CYC_CLK + 1);
  localparam int PW      = $clog2(PRESCALE + 1);

  typedef enum logic [1:0] {PH_AZ, PH_INT, PH_DE, PH_ZI} phase_t;

  phase_t        ph;
  logic [CW-1:0] cyc;
  logic [TW-1:0] tmr;
  logic [PW-1:0] pre;
  logic          pol, heavy;
  logic          k;
  logic [3:0]    h, t, u;
  logic          nk;
  logic [3:0]    nh, nt, nu;

  wire tick    = (pre == PW'(PRESCALE - 1));
  wire crossed = (cmp_i != pol);
  wire at_max  = k && (h == 4'd9) && (t == 4'd9) && (u == 4'd9);
  wire zi_done = heavy ? (tmr == TW'(ZI_OVR - 1))
                       : ((tmr >= TW'(ZI_MIN - 1) && !crossed) || tmr == TW'(ZI_MAX - 1));

  always_comb begin
    nk = k;
    nh = h;
    nt = t;
    nu = u + 4'd1;
    if (u == 4'd9) begin
      nu = 4'd0;
      nt = t + 4'd1;
      if (t == 4'd9) begin
        nt = 4'd0;
        nh = h + 4'd1;
        if (h == 4'd9) begin
          nh = 4'd0;
          nk = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph        <= PH_AZ;
      cyc       <= '0;
      tmr       <= '0;
      pre       <= '0;
      pol       <= 1'b0;
      heavy     <= 1'b0;
      k         <= 1'b0;
      h         <= '0;
      t         <= '0;
      u         <= '0;
      res_neg_o <= 1'b0;
      res_k_o   <= 1'b0;
      res_h_o   <= '0;
      res_t_o   <= '0;
      res_u_o   <= '0;
      ovr_o     <= 1'b0;
      valid_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      cyc     <= cyc + CW'(1);
      case (ph)
        PH_AZ: begin
          if (cyc == CW'(CYC_CLK - 1)) begin
            ph  <= PH_INT;
            cyc <= '0;
            tmr <= '0;
          end
        end
        PH_INT: begin
          tmr <= tmr + TW'(1);
          if (tmr == TW'(INT_CLK - 1)) begin
            pol <= cmp_i;
            ph  <= PH_DE;
            pre <= '0;
            k   <= 1'b0;
            h   <= '0;
            t   <= '0;
            u   <= '0;
          end
        end
        PH_DE: begin
          pre <= pre + PW'(1);
          if (tick) begin
            pre <= '0;
            if (crossed || at_max) begin
              ph        <= PH_ZI;
              tmr       <= '0;
              valid_o   <= 1'b1;
              res_neg_o <= ~pol;
              ovr_o     <= !crossed;
              heavy     <= !crossed;
              res_k_o   <= crossed ? k : 1'b0;
              res_h_o   <= crossed ? h : 4'd0;
              res_t_o   <= crossed ? t : 4'd0;
              res_u_o   <= crossed ? u : 4'd0;
            end else begin
              k <= nk;
              h <= nh;
              t <= nt;
              u <= nu;
            end
          end
        end
        PH_ZI: begin
          tmr <= tmr + TW'(1);
          if (zi_done) begin
            ph    <= PH_AZ;
            heavy <= 1'b0;
          end
        end
        default: ph <= PH_AZ;
      endcase
    end
  end

  assign az_o    = (ph == PH_AZ);
  assign int_o   = (ph == PH_INT);
  assign de_up_o = (ph == PH_DE) && !pol;
  assign de_dn_o = (ph == PH_DE) && pol;
  assign zi_o    = (ph == PH_ZI);
  assign short_o = (ph != PH_INT);
endmodule

// File: rtl/dualslope_seq_chk.sv
module dualslope_seq_chk #(
  parameter int INT_CLK = 4000,
  parameter int CYC_CLK = 16000,
  parameter int ZI_MIN  = 11,
  parameter int ZI_MAX  = 140,
  parameter int ZI_OVR  = 740
) (
  input logic       clk,
  input logic       rst,
  input logic       az_o,
  input logic       int_o,
  input logic       de_up_o,
  input logic       de_dn_o,
  input logic       zi_o,
  input logic       short_o,
  input logic       res_neg_o,
  input logic       res_k_o,
  input logic [3:0] res_h_o,
  input logic [3:0] res_t_o,
  input logic [3:0] res_u_o,
  input logic       ovr_o,
  input logic       valid_o
);
  int   zcnt, icnt, pcnt;
  logic int_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      zcnt  <= 0;
      icnt  <= 0;
      pcnt  <= 0;
      int_q <= 1'b0;
    end else begin
      zcnt  <= zi_o ? zcnt + 1 : 0;
      icnt  <= int_o ? icnt + 1 : 0;
      pcnt  <= (int_o && !int_q) ? 1 : pcnt + 1;
      int_q <= int_o;
    end
  end

  a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
    $countones({az_o, int_o, de_up_o, de_dn_o, zi_o}) == 1);
  a_r2_int_after_az: assert property (@(posedge clk) disable iff (rst)
    $rose(int_o) |-> $past(az_o));
  a_r2_zi_after_de: assert property (@(posedge clk) disable iff (rst)
    $rose(zi_o) |-> $past(de_up_o || de_dn_o));
  a_r2_az_after_zi: assert property (@(posedge clk) disable iff (rst)
    ($rose(az_o) && !$past(rst)) |-> $past(zi_o));
  a_r3_short_open: assert property (@(posedge clk) disable iff (rst)
    int_o |-> !short_o);
  a_r3_short_closed: assert property (@(posedge clk) disable iff (rst)
    (az_o || zi_o || de_up_o || de_dn_o) |-> short_o);
  a_r4_int_len: assert property (@(posedge clk) disable iff (rst)
    ($fell(int_o) && !$past(rst)) |-> (icnt == INT_CLK));
  a_r5_sign: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (res_neg_o == $past(de_up_o)));
  a_r6_bcd_digits: assert property (@(posedge clk) disable iff (rst)
    (res_h_o <= 4'd9) && (res_t_o <= 4'd9) && (res_u_o <= 4'd9));
  a_r7_pulse: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (!valid_o && !$past(rst)) |->
      $stable({res_neg_o, res_k_o, res_h_o, res_t_o, res_u_o, ovr_o}));
  a_r8_ovr_zero: assert property (@(posedge clk) disable iff (rst)
    ovr_o |-> ({res_k_o, res_h_o, res_t_o, res_u_o} == 13'd0));
  a_r9_zi_window: assert property (@(posedge clk) disable iff (rst)
    ($fell(zi_o) && !$past(rst) && !ovr_o) |-> (zcnt >= ZI_MIN && zcnt <= ZI_MAX));
  a_r10_zi_recovery: assert property (@(posedge clk) disable iff (rst)
    ($fell(zi_o) && !$past(rst) && ovr_o) |-> (zcnt == ZI_OVR));
  a_r11_period: assert property (@(posedge clk) disable iff (rst)
    (int_o && !int_q) |-> (pcnt == CYC_CLK));
endmodule

bind dualslope_seq dualslope_seq_chk #(
  .INT_CLK(INT_CLK), .CYC_CLK(CYC_CLK), .ZI_MIN(ZI_MIN), .ZI_MAX(ZI_MAX), .ZI_OVR(ZI_OVR)
) u_chk (
  .clk(clk), .rst(rst), .az_o(az_o), .int_o(int_o), .de_up_o(de_up_o), .de_dn_o(de_dn_o),
  .zi_o(zi_o), .short_o(short_o), .res_neg_o(res_neg_o), .res_k_o(res_k_o),
  .res_h_o(res_h_o), .res_t_o(res_t_o), .res_u_o(res_u_o), .ovr_o(ovr_o), .valid_o(valid_o)
);

// File: tb/dualslope_seq_test.sv
`timescale 1ns/1ps
module dualslope_seq_test;
  localparam int P     = 2;
  localparam int INTC  = 1000;
  localparam int CYCC  = 4000;
  localparam int ZMIN  = 11;
  localparam int ZMAX  = 140;
  localparam int ZOVR  = 740;
  localparam int NSC   = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmp = 1'b0;
  logic az, intg, dup, ddn, zi, sh, neg, kd, ovr, vld;
  logic [3:0] hd, td, ud;

  always #4 clk = ~clk;

  dualslope_seq #(.PRESCALE(P), .INT_COUNTS(INTC), .CYCLE_COUNTS(CYCC),
                  .ZI_MIN(ZMIN), .ZI_MAX(ZMAX), .ZI_OVR(ZOVR)) uut (
    .clk(clk), .rst(rst), .cmp_i(cmp), .az_o(az), .int_o(intg), .de_up_o(dup),
    .de_dn_o(ddn), .zi_o(zi), .short_o(sh), .res_neg_o(neg), .res_k_o(kd),
    .res_h_o(hd), .res_t_o(td), .res_u_o(ud), .ovr_o(ovr), .valid_o(vld));

  int sc_s[NSC] = '{1, 0, 1, 0, 1, 1, 0, 1, 0};
  int sc_n[NSC] = '{0, 1234, 1999, 5000, 7, 2000, 999, 1, 500};
  int sc_y[NSC] = '{5, 60, 200, 3, 20, 1, 11, 0, 30};

  int checks = 0, fails = 0;
  int m_ph = 0, m_t = 0, m_cyc = 0, m_pol = 0, m_heavy = 0;
  int m_val = 0, m_neg = 0, m_ovr = 0, m_valid = 0;
  int started = 0, done = 0, running = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  function automatic int dut_val();
    return int'(kd) * 1000 + int'(hd) * 100 + int'(td) * 10 + int'(ud);
  endfunction

  always @(posedge clk) begin
    running = 1;
    if (rst) begin
      m_ph = 0; m_t = 0; m_cyc = 0; m_pol = 0; m_heavy = 0;
      m_val = 0; m_neg = 0; m_ovr = 0; m_valid = 0;
    end else begin
      m_valid = 0;
      if (m_ph == 0 && m_cyc == CYCC * P - 1) begin
        m_ph = 1; m_cyc = 0; m_t = 0; started++;
      end else begin
        m_cyc++;
        if (m_ph == 1) begin
          m_t++;
          if (m_t == INTC * P) begin m_pol = int'(cmp); m_ph = 2; m_t = 0; end
        end else if (m_ph == 2) begin
          m_t++;
          if (m_t % P == 0) begin
            if (int'(cmp) != m_pol) begin
              m_val = m_t / P - 1; m_ovr = 0; m_neg = !m_pol; m_valid = 1; m_ph = 3; m_t = 0;
            end else if (m_t / P == 2000) begin
              m_val = 0; m_ovr = 1; m_neg = !m_pol; m_valid = 1; m_heavy = 1; m_ph = 3; m_t = 0;
            end
          end
        end else if (m_ph == 3) begin
          m_t++;
          if (m_heavy ? (m_t == ZOVR) : ((m_t >= ZMIN && int'(cmp) == m_pol) || m_t == ZMAX)) begin
            m_ph = 0; m_heavy = 0; done++;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (running) begin
      string tag;
      int ev, av;
      ev = {(m_ph == 0), (m_ph == 1), (m_ph == 2 && !m_pol), (m_ph == 2 && m_pol), (m_ph == 3)};
      av = {az, intg, dup, ddn, zi};
      case (m_ph)
        0: tag = "R11";
        1: tag = "R4";
        2: tag = "R5";
        default: tag = m_heavy ? "R10" : "R9";
      endcase
      chk(av == ev, tag, av, ev);
      chk($countones({az, intg, dup, ddn, zi}) == 1, "R2", av, ev);
      chk(int'(sh) == int'(m_ph != 1), "R3", int'(sh), int'(m_ph != 1));
      chk(int'(vld) == m_valid, "R7", int'(vld), m_valid);
      chk(dut_val() == m_val, m_ovr ? "R8" : "R6", dut_val(), m_val);
      chk(int'(ovr) == m_ovr, "R8", int'(ovr), m_ovr);
      chk(int'(neg) == m_neg, "R5", int'(neg), m_neg);
    end
    begin
      int ix;
      ix = started - 1;
      if (ix < 0) ix = 0;
      if (ix >= NSC) ix = NSC - 1;
      if (m_ph == 0 || m_ph == 1) cmp <= sc_s[ix][0];
      else if (m_ph == 2) cmp <= (m_t >= sc_n[ix] * P) ? !m_pol[0] : m_pol[0];
      else cmp <= (m_t + 1 >= sc_y[ix]) ? m_pol[0] : !m_pol[0];
    end
  end

  task automatic check_reset();
    chk({az, intg, dup, ddn, zi} == 5'b10000, "R1", int'({az, intg, dup, ddn, zi}), 16);
    chk(!vld && !ovr && !neg, "R1", int'({vld, ovr, neg}), 0);
    chk(dut_val() == 0, "R1", dut_val(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_reset();
    rst = 1'b0;
    wait (done >= 8);
    wait (m_ph == 2);
    repeat (30) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check_reset();
    rst = 1'b0;
    wait (done >= 9);
    repeat (20) @(negedge clk);
    summary();
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog expired actual=%0d expected=%0d", done, 9);
    summary();
  end
endmodule